// File: doc/BRIEF.md
# First-Layer Binary-Weight Convolver

This block computes the opening convolution layer of a binarized network. It takes a raster stream of three-channel pixels, each channel a signed 20-bit fixed-point value. Two row buffers and a 3x3 register window build the neighbourhood of every pixel position. Each neighbourhood is convolved with one 27-bit binary kernel per output channel. There is no multiplier in the convolution: a weight bit of 1 adds the sample and a weight bit of 0 subtracts it. All three input channels are reduced into one accumulator in the same cycle.

The accumulated sum then goes through a folded normalization, y = k*S + h. Each output channel has its own signed 16-bit k and h, and there is no separate bias. Only the sign of y leaves the block, as one bit per cycle. Samples that fall outside the image take a fixed padding value set by a parameter.

Kernels and k/h pairs are written through a small configuration port between frames. At the end of each frame the block flushes its last row and column internally, so the next frame can follow at once.

Top module: `first_layer_bconv`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` is 0. Once the internal reset has settled, `in_ready` is 1 with the block waiting for the first pixel of a frame.
- R2: For output channel o at image position (r,c), `out_bit` is 1 when k[o]*S + h[o] >= 0 and 0 otherwise. S is the signed sum of the 27 window terms, and k and h are signed 16-bit values. Channel ch of a pixel sits at `in_pix[ch*20 +: 20]` in two's complement.
- R3: Weight bit index ch*9 + ky*3 + kx belongs to channel ch, kernel row ky (0 = row above, 2 = row below) and kernel column kx (0 = left, 2 = right). Bit value 1 adds the sample and bit value 0 subtracts it.
- R4: Window samples whose row or column lies outside the image use the value of parameter PAD_VAL, on all three channels.
- R5: Outputs come out in raster order of positions, and each position emits N_OUT bits for channels 0 up to N_OUT-1. A frame produces exactly IMG_H*IMG_W*N_OUT bits.
- R6: A pixel is taken only in a cycle with both `in_valid` and `in_ready` high. Idle cycles on the input change no output value and no output order.
- R7: With `in_valid` held high, the output bits of one image row are back to back. Consecutive rows are separated by exactly one idle cycle, so a frame spans IMG_H*IMG_W*N_OUT + IMG_H - 1 cycles from its first valid bit to its last.
- R8: A write with `wt_we` or `kh_we` high stores `wt_bits`, or the pair `k_val`/`h_val`, for the channel given by `cfg_addr`. Each channel is then normalized with its own pair.
- R9: A window filled with the most negative pixel value under all-zero weights is summed and normalized without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Pixel present on `in_pix` |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_pix | input | 3*DW | Three signed channels, channel ch at bits [ch*DW +: DW] |
| cfg_addr | input | OC_W | Output channel addressed by a configuration write |
| wt_we | input | 1 | Write `wt_bits` for channel `cfg_addr` |
| wt_bits | input | 27 | Binary kernel, bit ch*9+ky*3+kx |
| kh_we | input | 1 | Write `k_val` and `h_val` for channel `cfg_addr` |
| k_val | input | PW | Signed scale k |
| h_val | input | PW | Signed offset h |
| out_valid | output | 1 | `out_bit` carries a result |
| out_bit | output | 1 | Sign of k*S+h, 1 for non-negative |

## Verification
The assertions take for granted that configuration writes never happen while an output channel is being computed. Kernels and k/h pairs are therefore treated as frozen for a whole frame, and the bench writes them only after every bit of the previous frame has appeared. They also take for granted that pixel values stay in the signed 20-bit range, so the accumulator bound holds. The bench respects that by sign-extending every generated value from exactly 20 bits, including the extreme frame built from the most negative value. Input idle cycles are inserted only by lowering `in_valid`, never by changing data under a pending handshake.

// File: rtl/bconv_pkg.sv
package bconv_pkg;
  localparam int N_CH = 3;
  localparam int KSZ  = 3;
  localparam int TAPS = N_CH * KSZ * KSZ;

  typedef enum logic {
    ST_STEP = 1'b0,
    ST_CONV = 1'b1
  } step_st_e;
endpackage

// File: rtl/bconv_ctrl.sv
module bconv_ctrl
  import bconv_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int IMG_H = 6,
  parameter int N_OUT = 4,
  parameter int OC_W  = 2,
  parameter int IC_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            shift,
  output logic            pix_real,
  output logic [IC_W-1:0] col,
  output logic            top_pad,
  output logic            left_pad,
  output logic            conv_act,
  output logic [OC_W-1:0] oc
);
  localparam int IR_W = $clog2(IMG_H + 1);

  step_st_e        st_q, st_d;
  logic [IR_W-1:0] ir_q, ir_d;
  logic [IC_W-1:0] ic_q, ic_d;
  logic [OC_W-1:0] oc_q, oc_d;
  logic            at_last, can_step, fire, due;

  always_comb begin
    at_last  = (st_q == ST_CONV) && (oc_q == OC_W'(N_OUT - 1));
    can_step = (st_q == ST_STEP) || at_last;
    pix_real = (ir_q < IR_W'(IMG_H)) && (ic_q < IC_W'(IMG_W));
    in_ready = can_step && pix_real;
    fire     = can_step && (!pix_real || in_valid);
    due      = (ir_q != '0) && (ic_q != '0);
    st_d = st_q;
    ir_d = ir_q;
    ic_d = ic_q;
    oc_d = oc_q;
    if (fire) begin
      if (ic_q == IC_W'(IMG_W)) begin
        ic_d = '0;
        ir_d = (ir_q == IR_W'(IMG_H)) ? '0 : ir_q + 1'b1;
      end else begin
        ic_d = ic_q + 1'b1;
      end
      st_d = due ? ST_CONV : ST_STEP;
      oc_d = '0;
    end else if (st_q == ST_CONV) begin
      if (at_last) st_d = ST_STEP;
      else         oc_d = oc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_STEP;
      ir_q <= '0;
      ic_q <= '0;
      oc_q <= '0;
    end else begin
      st_q <= st_d;
      ir_q <= ir_d;
      ic_q <= ic_d;
      oc_q <= oc_d;
    end
  end

  assign shift    = fire;
  assign col      = ic_q;
  assign top_pad  = (int'(ir_q) < 2);
  assign left_pad = (int'(ic_q) < 2);
  assign conv_act = (st_q == ST_CONV);
  assign oc       = oc_q;

  // R6
  no_step_without_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (ic_q == $past(ic_q) && ir_q == $past(ir_q)));

  // R5
  oc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV) |-> (int'(oc_q) < N_OUT));

  // R7
  conv_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV && !at_last) |=> (st_q == ST_CONV && oc_q == $past(oc_q) + 1'b1));
endmodule

// File: rtl/bconv_window.sv
module bconv_window
  import bconv_pkg::*;
#(
  parameter int IMG_W   = 8,
  parameter int DW      = 20,
  parameter int PAD_VAL = 0,
  parameter int IC_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic                 pix_real,
  input  logic [IC_W-1:0]      col,
  input  logic                 top_pad,
  input  logic                 left_pad,
  input  logic [N_CH*DW-1:0]   in_pix,
  output logic [TAPS*DW-1:0]   win_flat
);
  localparam logic signed [DW-1:0] PAD = DW'(PAD_VAL);

  logic signed [DW-1:0] row_up1 [0:IMG_W][N_CH];
  logic signed [DW-1:0] row_up2 [0:IMG_W][N_CH];
  logic signed [DW-1:0] win_q   [KSZ][KSZ][N_CH];
  logic signed [DW-1:0] new_pix [N_CH];
  logic                 top_q, left_q;

  always_comb begin
    for (int ch = 0; ch < N_CH; ch++)
      new_pix[ch] = pix_real ? $signed(in_pix[ch*DW +: DW]) : PAD;
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      for (int ch = 0; ch < N_CH; ch++) begin
        row_up2[col][ch] <= row_up1[col][ch];
        row_up1[col][ch] <= new_pix[ch];
        for (int ky = 0; ky < KSZ; ky++)
          for (int kx = 0; kx < KSZ - 1; kx++)
            win_q[ky][kx][ch] <= win_q[ky][kx+1][ch];
        win_q[0][KSZ-1][ch] <= row_up2[col][ch];
        win_q[1][KSZ-1][ch] <= row_up1[col][ch];
        win_q[2][KSZ-1][ch] <= new_pix[ch];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= 1'b1;
      left_q <= 1'b1;
    end else if (shift) begin
      top_q  <= top_pad;
      left_q <= left_pad;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    for (genvar ky = 0; ky < KSZ; ky++) begin : g_ky
      for (genvar kx = 0; kx < KSZ; kx++) begin : g_kx
        localparam int T = ch*KSZ*KSZ + ky*KSZ + kx;
        if (ky == 0 && kx == 0) begin : g_corner
          assign win_flat[T*DW +: DW] = (top_q || left_q) ? PAD : win_q[ky][kx][ch];
        end else if (ky == 0) begin : g_top
          assign win_flat[T*DW +: DW] = top_q ? PAD : win_q[ky][kx][ch];
        end else if (kx == 0) begin : g_left
          assign win_flat[T*DW +: DW] = left_q ? PAD : win_q[ky][kx][ch];
        end else begin : g_mid
          assign win_flat[T*DW +: DW] = win_q[ky][kx][ch];
        end
      end
    end
  end
endmodule

// File: rtl/bconv_params.sv
module bconv_params
  import bconv_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int PW    = 16,
  parameter int OC_W  = 2
) (
  input  logic                 clk,
  input  logic [OC_W-1:0]      cfg_addr,
  input  logic                 wt_we,
  input  logic [TAPS-1:0]      wt_bits,
  input  logic                 kh_we,
  input  logic signed [PW-1:0] k_val,
  input  logic signed [PW-1:0] h_val,
  input  logic [OC_W-1:0]      rd_oc,
  output logic [TAPS-1:0]      wt_sel,
  output logic signed [PW-1:0] k_sel,
  output logic signed [PW-1:0] h_sel
);
  logic [TAPS-1:0]      wt_mem [N_OUT];
  logic signed [PW-1:0] k_mem  [N_OUT];
  logic signed [PW-1:0] h_mem  [N_OUT];
  logic                 addr_ok;

  assign addr_ok = (int'(cfg_addr) < N_OUT);

  always_ff @(posedge clk) begin
    if (wt_we && addr_ok) wt_mem[cfg_addr] <= wt_bits;
    if (kh_we && addr_ok) begin
      k_mem[cfg_addr] <= k_val;
      h_mem[cfg_addr] <= h_val;
    end
  end

  assign wt_sel = wt_mem[rd_oc];
  assign k_sel  = k_mem[rd_oc];
  assign h_sel  = h_mem[rd_oc];
endmodule

// File: rtl/bconv_mac.sv
module bconv_mac
  import bconv_pkg::*;
#(
  parameter int DW = 20,
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [TAPS*DW-1:0]   win_flat,
  input  logic [TAPS-1:0]      wt_sel,
  input  logic signed [PW-1:0] k_sel,
  input  logic signed [PW-1:0] h_sel,
  output logic                 out_valid,
  output logic                 out_bit
);
  localparam int    ACC_W   = DW + $clog2(TAPS);
  localparam int    PRD_W   = PW + ACC_W;
  localparam int    YW      = PRD_W + 1;
  localparam longint ACC_MAX = longint'(TAPS) * (longint'(1) << (DW - 1));

  logic signed [ACC_W-1:0] acc;
  logic signed [PRD_W-1:0] prod;
  logic signed [YW-1:0]    y;

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) begin
      if (wt_sel[t]) acc = acc + ACC_W'($signed(win_flat[t*DW +: DW]));
      else           acc = acc - ACC_W'($signed(win_flat[t*DW +: DW]));
    end
    prod = k_sel * acc;
    y    = YW'(prod) + YW'(h_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= en;
      if (en) out_bit <= ~y[YW-1];
    end
  end

  // R9
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (acc <= ACC_MAX && acc >= -ACC_MAX));
endmodule

// File: rtl/first_layer_bconv.sv
module first_layer_bconv
  import bconv_pkg::*;
#(
  parameter int IMG_W   = 8,
  parameter int IMG_H   = 6,
  parameter int N_OUT   = 4,
  parameter int DW      = 20,
  parameter int PW      = 16,
  parameter int PAD_VAL = 0,
  localparam int OC_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3*DW-1:0]      in_pix,
  input  logic [OC_W-1:0]      cfg_addr,
  input  logic                 wt_we,
  input  logic [26:0]          wt_bits,
  input  logic                 kh_we,
  input  logic signed [PW-1:0] k_val,
  input  logic signed [PW-1:0] h_val,
  output logic                 out_valid,
  output logic                 out_bit
);
  localparam int IC_W = $clog2(IMG_W + 1);

  logic [1:0]           rst_sync;
  logic                 rst_ns;
  logic                 shift, pix_real, top_pad, left_pad, conv_act;
  logic [IC_W-1:0]      col;
  logic [OC_W-1:0]      oc;
  logic [TAPS*DW-1:0]   win_flat;
  logic [TAPS-1:0]      wt_sel;
  logic signed [PW-1:0] k_sel, h_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  bconv_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .N_OUT(N_OUT), .OC_W(OC_W), .IC_W(IC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .in_valid(in_valid), .in_ready(in_ready),
    .shift(shift), .pix_real(pix_real), .col(col), .top_pad(top_pad),
    .left_pad(left_pad), .conv_act(conv_act), .oc(oc)
  );

  bconv_window #(.IMG_W(IMG_W), .DW(DW), .PAD_VAL(PAD_VAL), .IC_W(IC_W)) u_win (
    .clk(clk), .rst_n(rst_ns), .shift(shift), .pix_real(pix_real), .col(col),
    .top_pad(top_pad), .left_pad(left_pad), .in_pix(in_pix), .win_flat(win_flat)
  );

  bconv_params #(.N_OUT(N_OUT), .PW(PW), .OC_W(OC_W)) u_par (
    .clk(clk), .cfg_addr(cfg_addr), .wt_we(wt_we), .wt_bits(wt_bits),
    .kh_we(kh_we), .k_val(k_val), .h_val(h_val), .rd_oc(oc),
    .wt_sel(wt_sel), .k_sel(k_sel), .h_sel(h_sel)
  );

  bconv_mac #(.DW(DW), .PW(PW)) u_mac (
    .clk(clk), .rst_n(rst_ns), .en(conv_act), .win_flat(win_flat),
    .wt_sel(wt_sel), .k_sel(k_sel), .h_sel(h_sel),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    conv_act |-> !(wt_we || kh_we));
endmodule

// File: tb/first_layer_bconv_tb.sv
`timescale 1ns/1ps
module first_layer_bconv_tb;
  localparam int W = 8, H = 6, N = 4, DW = 20, PW = 16, PADV = 37;
  localparam int TOTAL = W * H * N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_ready, wt_we, kh_we, out_valid, out_bit;
  logic [3*DW-1:0] in_pix;
  logic [1:0] cfg_addr;
  logic [26:0] wt_bits;
  logic signed [PW-1:0] k_val, h_val;

  first_layer_bconv #(.IMG_W(W), .IMG_H(H), .N_OUT(N), .DW(DW), .PW(PW), .PAD_VAL(PADV)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .cfg_addr(cfg_addr), .wt_we(wt_we), .wt_bits(wt_bits), .kh_we(kh_we),
    .k_val(k_val), .h_val(h_val), .out_valid(out_valid), .out_bit(out_bit)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, got = 0, first_cyc = 0, last_cyc = 0;
  int img [H][W][3];
  logic [26:0] wts [N];
  int kk [N], hh [N];
  bit expb [TOTAL];
  string tag = "R5";
  int unsigned seed = 32'h1F2E3D4C;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int sx(int unsigned v, int bits);
    int m = int'(v & ((32'd1 << bits) - 1));
    if (m >= (1 << (bits - 1))) m -= (1 << bits);
    return m;
  endfunction

  always @(posedge clk) cyc++;

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(negedge clk) if (out_valid && rst_n) begin
    if (got == 0) first_cyc = cyc;
    last_cyc = cyc;
    if (got >= TOTAL) chk(0, "R5 extra bit", got, TOTAL - 1);
    else chk(out_bit == expb[got], tag, out_bit, expb[got]);
    got++;
  end

  function automatic void model();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        for (int o = 0; o < N; o++) begin
          longint s = 0, y;
          for (int ch = 0; ch < 3; ch++)
            for (int ky = 0; ky < 3; ky++)
              for (int kx = 0; kx < 3; kx++) begin
                int rr = r + ky - 1, cc = c + kx - 1, x;
                x = (rr < 0 || rr >= H || cc < 0 || cc >= W) ? PADV : img[rr][cc][ch];
                if (wts[o][ch*9 + ky*3 + kx]) s += x; else s -= x;
              end
          y = longint'(kk[o]) * s + longint'(hh[o]);
          expb[(r*W + c)*N + o] = (y >= 0);
        end
  endfunction

  task automatic load_cfg();
    for (int o = 0; o < N; o++) begin
      @(negedge clk);
      cfg_addr = 2'(o); wt_we = 1; kh_we = 1; wt_bits = wts[o];
      k_val = PW'(kk[o]); h_val = PW'(hh[o]);
    end
    @(negedge clk);
    wt_we = 0; kh_we = 0;
  endtask

  task automatic run_frame(bit gaps, bit span_chk, string t);
    model();
    load_cfg();
    tag = t;
    got = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps) begin
          in_valid = 0;
          repeat (rnd() % 3) @(negedge clk);
        end
        for (int ch = 0; ch < 3; ch++) in_pix[ch*DW +: DW] = DW'(img[r][c][ch]);
        in_valid = 1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
    in_valid = 0;
    for (int i = 0; i < 3000 && got < TOTAL; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(got == TOTAL, "R5 bit count", got, TOTAL);
    if (span_chk) chk(last_cyc - first_cyc + 1 == TOTAL + H - 1, "R7 span", last_cyc - first_cyc + 1, TOTAL + H - 1);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_pix = '0; cfg_addr = '0; wt_we = 0; kh_we = 0;
    wt_bits = '0; k_val = '0; h_val = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    // Frame A: wide random values, continuous input (R2 R3 R4 R8 R7)
    for (int o = 0; o < N; o++) begin
      wts[o] = 27'(rnd()); kk[o] = sx(rnd(), 16); hh[o] = sx(rnd(), 16);
    end
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) for (int ch = 0; ch < 3; ch++)
      img[r][c][ch] = sx(rnd(), 20);
    run_frame(0, 1, "R2 R3 R8 wide");

    // Frame B: small values so h matters, input idle cycles (R6 R2 R8)
    for (int o = 0; o < N; o++) begin
      wts[o] = 27'(rnd()); kk[o] = int'(rnd() % 9) - 4; hh[o] = int'(rnd() % 401) - 200;
    end
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) for (int ch = 0; ch < 3; ch++)
      img[r][c][ch] = int'(rnd() % 32) - 16;
    run_frame(1, 0, "R6 R2 R8 stalled");

    // Frame C: zero image, all weights add, only padding contributes (R4)
    for (int o = 0; o < N; o++) begin
      wts[o] = '1; kk[o] = 1; hh[o] = -1 - 37 * o;
    end
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) for (int ch = 0; ch < 3; ch++)
      img[r][c][ch] = 0;
    run_frame(0, 1, "R4 padding");

    // Frame D: one weight bit set per channel (R3)
    for (int o = 0; o < N; o++) begin
      wts[o] = 27'(1) << (o * 7); kk[o] = 1; hh[o] = 0;
    end
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) for (int ch = 0; ch < 3; ch++)
      img[r][c][ch] = int'(rnd() % 64) - 32;
    run_frame(1, 0, "R3 single tap");

    // Frame E: most negative pixels, subtracting weights (R9)
    kk[0] = -1; hh[0] = 32767;
    kk[1] = 1;  hh[1] = -32768;
    kk[2] = 0;  hh[2] = -1;
    kk[3] = 0;  hh[3] = 0;
    for (int o = 0; o < N; o++) wts[o] = '0;
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) for (int ch = 0; ch < 3; ch++)
      img[r][c][ch] = -(1 << 19);
    run_frame(0, 1, "R9 extreme");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule